// File: doc/BRIEF.md
# Subchannel Engine Binding Router

This block sits behind a command-stream parser and steers each method write to one of three downstream engines: a 2D engine, a 3D engine and a compute engine. Each write carries a method number, a subchannel number and a data value. The block keeps a table with one entry per subchannel. Each entry records whether the subchannel has been bound and, if so, the engine identifier it was bound to. The command stream fills in this table itself, using method 0.

Methods from 1 up to the reserved limit are kept for buffer control and are never forwarded. Every method at or above the limit goes to the engine that its subchannel is bound to. A forwarded write shows up one clock later on exactly one engine port, as a single-cycle valid pulse carrying the method and the value. Protocol violations drop the write and raise sticky error flags. Only reset clears those flags.

Top module: `subch_route`

## Requirements
- R1: During and after reset every subchannel entry is unbound, all four error flags are low and no engine port valid is high.
- R2: A write with method 0 to an unbound subchannel binds that subchannel to the engine ID held in the low 16 bits of the value. No engine port is driven as a result.
- R3: A method-0 write to a subchannel that is already bound sets err_double_bind one cycle later. The existing binding stays as it was.
- R4: A write with a method in 1 to 0xFF is not forwarded, and err_reserved is set one cycle later.
- R5: A write with method 0x100 or above, to a subchannel bound to 0x902D, 0xB197 or 0xB1C0, raises the valid of the 2D, 3D or compute port respectively in the next cycle. That port carries the write's method and value.
- R6: At most one engine port valid is high in any cycle, and each forwarded write produces exactly one single-cycle pulse.
- R7: A write with method 0x100 or above to an unbound subchannel is dropped, and err_unbound is set one cycle later.
- R8: A write with method 0x100 or above to a subchannel bound to any other ID is dropped, and err_unknown is set one cycle later.
- R9: Once an error flag is set, it stays set until reset.
- R10: While wr_valid is low, the table, the flags and the engine ports do not change, and no port valid is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A method write is present this cycle |
| wr_method | input | 13 | Method number |
| wr_subch | input | 3 | Subchannel number |
| wr_data | input | 32 | Method value |
| e2d_valid | output | 1 | Write pulse to the 2D engine |
| e2d_method | output | 13 | Method for the 2D engine |
| e2d_data | output | 32 | Value for the 2D engine |
| e3d_valid | output | 1 | Write pulse to the 3D engine |
| e3d_method | output | 13 | Method for the 3D engine |
| e3d_data | output | 32 | Value for the 3D engine |
| ecp_valid | output | 1 | Write pulse to the compute engine |
| ecp_method | output | 13 | Method for the compute engine |
| ecp_data | output | 32 | Value for the compute engine |
| err_double_bind | output | 1 | Sticky: a bound subchannel was bound again |
| err_unbound | output | 1 | Sticky: a write used an unbound subchannel |
| err_reserved | output | 1 | Sticky: a reserved buffer method was written |
| err_unknown | output | 1 | Sticky: a subchannel bound to an unsupported ID was used |

## Verification
The assertions rely on reset being held low at the first clock edge, and on wr_valid, wr_method and wr_data always carrying known values. Given those two conditions, each property follows from the current write's method class alone, so illegal command streams are allowed too. The bench drives every input to a defined value from time zero and holds reset through the first edges. Its random mix uses only the four method classes: bind, reserved, forward and idle. Bind values are drawn both from the three supported IDs and from arbitrary other IDs.

// File: rtl/subch_route_pkg.sv
package subch_route_pkg;
   localparam int ID_W    = 16;
   localparam int NUM_ENG = 3;
   localparam int ENG_2D  = 0;
   localparam int ENG_3D  = 1;
   localparam int ENG_CP  = 2;

   typedef logic [ID_W-1:0] eng_id_t;

   // Engine identifier matched by each output port, indexed by port number
   localparam eng_id_t ENG_ID [NUM_ENG] = '{16'h902D, 16'hB197, 16'hB1C0};
endpackage

// File: rtl/subch_route_tbl.sv
module subch_route_tbl
   import subch_route_pkg::*;
#(
   parameter int SUBCH_W   = 3,
   parameter int NUM_SUBCH = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [SUBCH_W-1:0] idx,
   input  eng_id_t            wr_id,
   output logic               ent_valid,
   output eng_id_t            ent_id
);
   logic [NUM_SUBCH-1:0] vld;
   eng_id_t              ids [NUM_SUBCH];

   for (genvar i = 0; i < NUM_SUBCH; i++) begin : g_ent
      logic    v_q;
      eng_id_t id_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q  <= 1'b0;
            id_q <= '0;
         end else if (wr_en && idx == SUBCH_W'(i)) begin
            v_q  <= 1'b1;
            id_q <= wr_id;
         end
      end
      assign vld[i] = v_q;
      assign ids[i] = id_q;
   end

   assign ent_valid = vld[idx];
   assign ent_id    = ids[idx];
endmodule

// File: rtl/subch_route_dec.sv
module subch_route_dec
   import subch_route_pkg::*;
#(
   parameter int METHOD_W   = 13,
   parameter int RESV_LIMIT = 256
) (
   input  logic                wr_valid,
   input  logic [METHOD_W-1:0] wr_method,
   input  logic                ent_valid,
   input  eng_id_t             ent_id,
   output logic                tbl_wr,
   output logic [NUM_ENG-1:0]  fire,
   output logic                set_dbl,
   output logic                set_unb,
   output logic                set_res,
   output logic                set_unk
);
   localparam logic [METHOD_W-1:0] RESV_M = METHOD_W'(RESV_LIMIT);

   logic               is_bind, is_resv, is_fwd;
   logic [NUM_ENG-1:0] match;

   assign is_bind = wr_valid && (wr_method == '0);
   assign is_resv = wr_valid && (wr_method != '0) && (wr_method < RESV_M);
   assign is_fwd  = wr_valid && (wr_method >= RESV_M);

   for (genvar e = 0; e < NUM_ENG; e++) begin : g_match
      assign match[e] = (ent_id == ENG_ID[e]);
   end

   assign tbl_wr  = is_bind && !ent_valid;
   assign set_dbl = is_bind && ent_valid;
   assign set_res = is_resv;
   assign set_unb = is_fwd && !ent_valid;
   assign set_unk = is_fwd && ent_valid && (match == '0);
   assign fire    = (is_fwd && ent_valid) ? match : '0;
endmodule

// File: rtl/subch_route_port.sv
module subch_route_port #(
   parameter int METHOD_W = 13,
   parameter int DATA_W   = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fire,
   input  logic [METHOD_W-1:0] method_in,
   input  logic [DATA_W-1:0]   data_in,
   output logic                valid_q,
   output logic [METHOD_W-1:0] method_q,
   output logic [DATA_W-1:0]   data_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q  <= 1'b0;
         method_q <= '0;
         data_q   <= '0;
      end else begin
         valid_q <= fire;
         if (fire) begin
            method_q <= method_in;
            data_q   <= data_in;
         end
      end
   end
endmodule

// File: rtl/subch_route.sv
module subch_route
   import subch_route_pkg::*;
#(
   parameter int METHOD_W   = 13,
   parameter int SUBCH_W    = 3,
   parameter int NUM_SUBCH  = 8,
   parameter int DATA_W     = 32,
   parameter int RESV_LIMIT = 256
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_valid,
   input  logic [METHOD_W-1:0] wr_method,
   input  logic [SUBCH_W-1:0]  wr_subch,
   input  logic [DATA_W-1:0]   wr_data,
   output logic                e2d_valid,
   output logic [METHOD_W-1:0] e2d_method,
   output logic [DATA_W-1:0]   e2d_data,
   output logic                e3d_valid,
   output logic [METHOD_W-1:0] e3d_method,
   output logic [DATA_W-1:0]   e3d_data,
   output logic                ecp_valid,
   output logic [METHOD_W-1:0] ecp_method,
   output logic [DATA_W-1:0]   ecp_data,
   output logic                err_double_bind,
   output logic                err_unbound,
   output logic                err_reserved,
   output logic                err_unknown
);
   if (NUM_SUBCH != (1 << SUBCH_W)) begin : g_bad_subch
      $error("NUM_SUBCH must equal 2**SUBCH_W");
   end
   if (RESV_LIMIT < 1 || RESV_LIMIT >= (1 << METHOD_W)) begin : g_bad_resv
      $error("RESV_LIMIT must lie inside the method range");
   end
   if (DATA_W < ID_W) begin : g_bad_data
      $error("DATA_W must hold an engine ID");
   end

   logic               ent_valid;
   eng_id_t            ent_id;
   logic               tbl_wr;
   logic [NUM_ENG-1:0] fire;
   logic               set_dbl, set_unb, set_res, set_unk;

   logic                port_v [NUM_ENG];
   logic [METHOD_W-1:0] port_m [NUM_ENG];
   logic [DATA_W-1:0]   port_d [NUM_ENG];

   subch_route_tbl #(
      .SUBCH_W   (SUBCH_W),
      .NUM_SUBCH (NUM_SUBCH)
   ) i_tbl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (tbl_wr),
      .idx       (wr_subch),
      .wr_id     (wr_data[ID_W-1:0]),
      .ent_valid (ent_valid),
      .ent_id    (ent_id)
   );

   subch_route_dec #(
      .METHOD_W   (METHOD_W),
      .RESV_LIMIT (RESV_LIMIT)
   ) i_dec (
      .wr_valid  (wr_valid),
      .wr_method (wr_method),
      .ent_valid (ent_valid),
      .ent_id    (ent_id),
      .tbl_wr    (tbl_wr),
      .fire      (fire),
      .set_dbl   (set_dbl),
      .set_unb   (set_unb),
      .set_res   (set_res),
      .set_unk   (set_unk)
   );

   for (genvar e = 0; e < NUM_ENG; e++) begin : g_port
      subch_route_port #(
         .METHOD_W (METHOD_W),
         .DATA_W   (DATA_W)
      ) i_port (
         .clk       (clk),
         .rst_n     (rst_n),
         .fire      (fire[e]),
         .method_in (wr_method),
         .data_in   (wr_data),
         .valid_q   (port_v[e]),
         .method_q  (port_m[e]),
         .data_q    (port_d[e])
      );
   end

   assign e2d_valid  = port_v[ENG_2D];
   assign e2d_method = port_m[ENG_2D];
   assign e2d_data   = port_d[ENG_2D];
   assign e3d_valid  = port_v[ENG_3D];
   assign e3d_method = port_m[ENG_3D];
   assign e3d_data   = port_d[ENG_3D];
   assign ecp_valid  = port_v[ENG_CP];
   assign ecp_method = port_m[ENG_CP];
   assign ecp_data   = port_d[ENG_CP];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_double_bind <= 1'b0;
         err_unbound     <= 1'b0;
         err_reserved    <= 1'b0;
         err_unknown     <= 1'b0;
      end else begin
         err_double_bind <= err_double_bind | set_dbl;
         err_unbound     <= err_unbound     | set_unb;
         err_reserved    <= err_reserved    | set_res;
         err_unknown     <= err_unknown     | set_unk;
      end
   end
endmodule

// File: rtl/subch_route_chk.sv
module subch_route_chk #(
   parameter int METHOD_W   = 13,
   parameter int DATA_W     = 32,
   parameter int RESV_LIMIT = 256
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_valid,
   input logic [METHOD_W-1:0] wr_method,
   input logic [DATA_W-1:0]   wr_data,
   input logic                e2d_valid,
   input logic [METHOD_W-1:0] e2d_method,
   input logic [DATA_W-1:0]   e2d_data,
   input logic                e3d_valid,
   input logic [METHOD_W-1:0] e3d_method,
   input logic [DATA_W-1:0]   e3d_data,
   input logic                ecp_valid,
   input logic [METHOD_W-1:0] ecp_method,
   input logic [DATA_W-1:0]   ecp_data,
   input logic                err_double_bind,
   input logic                err_unbound,
   input logic                err_reserved,
   input logic                err_unknown
);
   localparam logic [METHOD_W-1:0] RESV_M = METHOD_W'(RESV_LIMIT);

   logic       any_v;
   logic [3:0] flags;
   assign any_v = e2d_valid | e3d_valid | ecp_valid;
   assign flags = {err_double_bind, err_unbound, err_reserved, err_unknown};

   // R6
   one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({e2d_valid, e3d_valid, ecp_valid}));

   // R5
   fwd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_v |-> ($past(wr_valid) && $past(wr_method) >= RESV_M));

   // R5
   fwd_2d_chk: assert property (@(posedge clk) disable iff (!rst_n)
      e2d_valid |-> (e2d_method == $past(wr_method) && e2d_data == $past(wr_data)));

   // R5
   fwd_3d_chk: assert property (@(posedge clk) disable iff (!rst_n)
      e3d_valid |-> (e3d_method == $past(wr_method) && e3d_data == $past(wr_data)));

   // R5
   fwd_cp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ecp_valid |-> (ecp_method == $past(wr_method) && ecp_data == $past(wr_data)));

   // R4
   reserved_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_method != '0 && wr_method < RESV_M) |=> (!any_v && err_reserved));

   // R2
   bind_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_method == '0) |=> !any_v);

   // R10
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid |=> (!any_v && $stable(flags)));

   // R9
   sticky_dbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_double_bind |=> err_double_bind);

   // R9
   sticky_unb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_unbound |=> err_unbound);

   // R9
   sticky_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_reserved |=> err_reserved);

   // R9
   sticky_unk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_unknown |=> err_unknown);
endmodule

bind subch_route subch_route_chk #(
   .METHOD_W   (METHOD_W),
   .DATA_W     (DATA_W),
   .RESV_LIMIT (RESV_LIMIT)
) i_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .wr_valid        (wr_valid),
   .wr_method       (wr_method),
   .wr_data         (wr_data),
   .e2d_valid       (e2d_valid),
   .e2d_method      (e2d_method),
   .e2d_data        (e2d_data),
   .e3d_valid       (e3d_valid),
   .e3d_method      (e3d_method),
   .e3d_data        (e3d_data),
   .ecp_valid       (ecp_valid),
   .ecp_method      (ecp_method),
   .ecp_data        (ecp_data),
   .err_double_bind (err_double_bind),
   .err_unbound     (err_unbound),
   .err_reserved    (err_reserved),
   .err_unknown     (err_unknown)
);

// File: tb/test_subch_route.sv
`timescale 1ns/1ps
module test_subch_route;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [12:0] wr_method = '0;
   logic [2:0]  wr_subch = '0;
   logic [31:0] wr_data = '0;
   logic        e2d_valid, e3d_valid, ecp_valid;
   logic [12:0] e2d_method, e3d_method, ecp_method;
   logic [31:0] e2d_data, e3d_data, ecp_data;
   logic        err_double_bind, err_unbound, err_reserved, err_unknown;

   int checks = 0;
   int fails  = 0;

   // Model state
   bit          m_bound [8];
   logic [15:0] m_id [8];
   logic [3:0]  m_flags;   // {double_bind, unbound, reserved, unknown}

   always #10 clk = ~clk;

   subch_route i_subch_route (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_method(wr_method),
      .wr_subch(wr_subch), .wr_data(wr_data),
      .e2d_valid(e2d_valid), .e2d_method(e2d_method), .e2d_data(e2d_data),
      .e3d_valid(e3d_valid), .e3d_method(e3d_method), .e3d_data(e3d_data),
      .ecp_valid(ecp_valid), .ecp_method(ecp_method), .ecp_data(ecp_data),
      .err_double_bind(err_double_bind), .err_unbound(err_unbound),
      .err_reserved(err_reserved), .err_unknown(err_unknown)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [3:0] act_flags();
      return {err_double_bind, err_unbound, err_reserved, err_unknown};
   endfunction

   function automatic logic [2:0] act_valids();
      return {ecp_valid, e3d_valid, e2d_valid};
   endfunction

   // Expected port index for an engine ID, 3 when unsupported (R5, R8)
   function automatic int eng_of(input logic [15:0] id);
      case (id)
         16'h902D: return 0;
         16'hB197: return 1;
         16'hB1C0: return 2;
         default:  return 3;
      endcase
   endfunction

   task automatic step(input bit v, input logic [12:0] m, input logic [2:0] s, input logic [31:0] d);
      logic [2:0]  ev = 3'b000;
      string       tag = "R10";
      logic [44:0] got;
      if (v) begin
         if (m == 13'h0) begin
            if (m_bound[s]) begin m_flags[3] = 1'b1; tag = "R3"; end
            else begin m_bound[s] = 1'b1; m_id[s] = d[15:0]; tag = "R2"; end
         end else if (m < 13'h100) begin
            m_flags[1] = 1'b1; tag = "R4";
         end else if (!m_bound[s]) begin
            m_flags[2] = 1'b1; tag = "R7";
         end else if (eng_of(m_id[s]) == 3) begin
            m_flags[0] = 1'b1; tag = "R8";
         end else begin
            ev[eng_of(m_id[s])] = 1'b1; tag = "R5";
         end
      end
      wr_valid = v; wr_method = m; wr_subch = s; wr_data = d;
      @(negedge clk);
      // R6: exactly the expected port pulses, others quiet
      chk(act_valids() == ev, {tag, "/R6 valids"}, 64'(act_valids()), 64'(ev));
      if (ev != 3'b000) begin
         got = ev[0] ? {e2d_method, e2d_data} : ev[1] ? {e3d_method, e3d_data} : {ecp_method, ecp_data};
         chk(got == {m, d}, {tag, " payload"}, 64'(got), 64'({m, d}));
      end
      chk(act_flags() == m_flags, {tag, "/R9 flags"}, 64'(act_flags()), 64'(m_flags));
   endtask

   task automatic do_reset();
      wr_valid = 1'b0; wr_method = '0; wr_subch = '0; wr_data = '0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      // R1
      chk(act_valids() == 3'b000, "R1 valids", 64'(act_valids()), 64'h0);
      chk(act_flags() == 4'b0000, "R1 flags", 64'(act_flags()), 64'h0);
      for (int i = 0; i < 8; i++) begin m_bound[i] = 1'b0; m_id[i] = '0; end
      m_flags = 4'b0000;
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic rand_phase(input int n);
      for (int k = 0; k < n; k++) begin
         int unsigned r = $urandom_range(99);
         logic [2:0]  s = 3'($urandom_range(7));
         logic [31:0] d = $urandom;
         if (r < 10) step(1'b0, 13'($urandom), s, d);
         else if (r < 22) begin
            int unsigned p = $urandom_range(3);
            logic [15:0] id = (p == 0) ? 16'h902D : (p == 1) ? 16'hB197 : (p == 2) ? 16'hB1C0 : 16'($urandom);
            step(1'b1, 13'h0, s, {d[31:16], id});
         end
         else if (r < 30) step(1'b1, 13'($urandom_range(1, 255)), s, d);
         else step(1'b1, 13'($urandom_range(256, 8191)), s, d);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      do_reset();                                          // R1
      step(1'b1, 13'h100, 3'd0, 32'h1111_0000);            // R7 unbound after reset
      do_reset();
      step(1'b1, 13'h0, 3'd1, 32'hABCD_902D);              // R2 bind 2D, upper bits ignored
      step(1'b1, 13'h100, 3'd1, 32'hDEAD_0001);            // R5 lowest forward method
      step(1'b0, 13'h100, 3'd1, 32'h0);                    // R10 idle, pulse gone (R6)
      step(1'b1, 13'h0, 3'd2, 32'h0000_B197);              // R2 bind 3D
      step(1'b1, 13'h0, 3'd7, 32'h0000_B1C0);              // R2 bind compute
      step(1'b1, 13'h1FFF, 3'd2, 32'h3333_3333);           // R5 3D, top method
      step(1'b1, 13'h0456, 3'd7, 32'h7777_7777);           // R5 compute
      step(1'b1, 13'h0457, 3'd7, 32'h7777_7778);           // R5 back-to-back
      step(1'b1, 13'h00FF, 3'd1, 32'h5555_5555);           // R4 top reserved
      step(1'b1, 13'h0001, 3'd1, 32'h5555_5556);           // R4 lowest reserved
      step(1'b1, 13'h0, 3'd1, 32'h0000_B197);              // R3 double bind
      step(1'b1, 13'h0200, 3'd1, 32'h2222_2222);           // R3 binding kept: still 2D
      step(1'b1, 13'h0300, 3'd0, 32'h0);                   // R7 unbound
      step(1'b1, 13'h0, 3'd4, 32'h0000_1234);              // R2 bind unsupported ID
      step(1'b1, 13'h0300, 3'd4, 32'h4444_4444);           // R8 unknown engine
      step(1'b0, 13'h0, 3'd4, 32'h0);                      // R10 / R9 flags hold
      do_reset();
      rand_phase(1500);
      do_reset();
      rand_phase(1500);
      finish_run();
   end
endmodule